// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block is the processor-facing end of an interrupt controller. A distributor supplies one pending bit and one priority value per source. The interface picks the most urgent eligible source and drives a single request line to its processor core. It offers a small register window through which software enables signalling, sets a priority mask, acknowledges the selected interrupt and ends its handling.

Acknowledging marks the returned source active, so it is not offered again. Writing its ID to the end-of-interrupt register clears it. Any ID above 510 read from the acknowledge register means that no interrupt is pending. The interface returns 1023 in that case, and the interrupt entry code keeps reading until it gets a valid ID. Source IDs 0 to 15 carry inter-processor interrupts and 16 to 31 carry local peripheral interrupts. Both ranges are completed the same way as the shared sources above them. Nesting, grouping and secure partitioning are not modelled.

Top module: `cpu_ack_iface`

## Requirements
- R1: After reset, signalling is disabled (control reads 0), the priority mask reads 0xF0, no source is active, `irqOut` is low and the acknowledge register reads 1023.
- R2: An acknowledge read returns, in bits [9:0] with bits [31:10] zero, the eligible source with the numerically lowest priority value. Among equal values the lowest ID wins.
- R3: A source is eligible only when its priority value is strictly below the mask (register select 1, bits [7:0]). A value equal to or above the mask is never signalled or returned.
- R4: Control bit 0 (register select 0) enables signalling. While it is 0, `irqOut` is low, acknowledge returns 1023 and no active state changes.
- R5: An acknowledge that returns a valid ID marks that source active. An active source is neither returned again nor counted for `irqOut` until its end-of-interrupt.
- R6: Writing an active source's ID to bits [9:0] of the end-of-interrupt register (register select 3) clears its active state, so that the source can be returned on the next acknowledge.
- R7: An end-of-interrupt write naming a source that is not active, or an ID at or above the source count, changes nothing.
- R8: `irqOut` is high exactly when signalling is enabled and some pending, not-active source passes the mask.
- R9: IDs 0-15 and 16-31 are acknowledged and completed through the same registers as higher IDs.
- R10: When no source is eligible, acknowledge returns 1023, which is above the 510 validity limit. Every valid ID returned is at most 510.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendVec | input | NUM_SRC | Pending and enabled bit per source from the distributor |
| prioVec | input | NUM_SRC*PRIO_W | Priority value per source, source n at bits [n*PRIO_W +: PRIO_W] |
| regSel | input | 2 | Register select: 0 control, 1 mask, 2 acknowledge, 3 end-of-interrupt |
| wrEn | input | 1 | Register write strobe; it takes precedence over rdEn |
| rdEn | input | 1 | Register read strobe; a read of select 2 is an acknowledge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the selected register, combinational |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is one where a pending source is blocked only by its own active state while other sources sit at the mask boundary. Reaching it needs an acknowledge, a later change of the pending and priority inputs, then end-of-interrupt writes that miss and then hit. The random phase interleaves acknowledges, end-of-interrupt writes aimed at both active and idle IDs, mask rewrites and enable toggles over sparse pending patterns and a small set of priorities that includes 0xF0. This keeps sources active, tied in priority or equal to the mask. Directed steps first cover the equal-to-mask case, ties, an end-of-interrupt write that misses, and acknowledges made while signalling is disabled.

// File: rtl/ackif_pkg.sv
package ackif_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int VALID_ID_MAX = 510;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PMR  = 2'd1,
    SEL_ACK  = 2'd2,
    SEL_EOI  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrPmr;
    logic ackRd;
    logic eoiWr;
  } strobe_t;
endpackage

// File: rtl/ackif_ctrl.sv
module ackif_ctrl
  import ackif_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  output strobe_t    strb
);
  regSel_e sel;
  logic    rdOnly;

  assign sel    = regSel_e'(regSel);
  assign rdOnly = rdEn & ~wrEn;

  always_comb begin
    strb        = '0;
    strb.wrCtrl = wrEn & (sel == SEL_CTRL);
    strb.wrPmr  = wrEn & (sel == SEL_PMR);
    strb.eoiWr  = wrEn & (sel == SEL_EOI);
    strb.ackRd  = rdOnly & (sel == SEL_ACK);
  end

  // An acknowledge and an end-of-interrupt never share a cycle (R7 relies on it)
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.wrPmr, strb.ackRd, strb.eoiWr}));
endmodule

// File: rtl/ackif_datapath.sv
module ackif_datapath
  import ackif_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8,
  parameter logic [PRIO_W-1:0] PMR_RESET = 8'hF0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        pendVec,
  input  logic [NUM_SRC*PRIO_W-1:0] prioVec,
  input  strobe_t                   strb,
  input  logic [1:0]                regSel,
  input  logic [31:0]               wrData,
  output logic [31:0]               rdData,
  output logic                      irqOut
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic                enReg;
  logic [PRIO_W-1:0]   pmrReg;
  logic [NUM_SRC-1:0]  activeVec;
  logic [PRIO_W-1:0]   prioArr [NUM_SRC];
  logic [NUM_SRC-1:0]  candVec;
  logic [IDX_W-1:0]    ackIdx;
  logic [PRIO_W-1:0]   bestPrio;
  logic                found;
  logic                ackValid;
  logic [ID_W-1:0]     ackId;
  logic [ID_W-1:0]     eoiId;
  logic [IDX_W-1:0]    eoiIdx;
  logic                eoiInRange;
  logic                eoiHit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cand
    assign prioArr[g] = prioVec[g*PRIO_W +: PRIO_W];
    assign candVec[g] = pendVec[g] & ~activeVec[g] & (prioArr[g] < pmrReg);
  end

  // Scan from the top down; "<=" lets a lower ID win a tie
  always_comb begin
    found    = 1'b0;
    ackIdx   = '0;
    bestPrio = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (candVec[i] && (!found || prioArr[i] <= bestPrio)) begin
        found    = 1'b1;
        ackIdx   = IDX_W'(i);
        bestPrio = prioArr[i];
      end
    end
  end

  assign ackValid   = enReg & found;
  assign ackId      = ackValid ? ID_W'(ackIdx) : SPURIOUS_ID;
  assign irqOut     = enReg & (|candVec);
  assign eoiId      = wrData[ID_W-1:0];
  assign eoiIdx     = eoiId[IDX_W-1:0];
  assign eoiInRange = (32'(eoiId) < NUM_SRC);
  assign eoiHit     = strb.eoiWr & eoiInRange & activeVec[eoiIdx];

  always_comb begin
    case (regSel_e'(regSel))
      SEL_CTRL: rdData = {31'd0, enReg};
      SEL_PMR:  rdData = {{(32-PRIO_W){1'b0}}, pmrReg};
      SEL_ACK:  rdData = {{(32-ID_W){1'b0}}, ackId};
      default:  rdData = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      pmrReg    <= PMR_RESET;
      activeVec <= '0;
    end else begin
      if (strb.wrCtrl) enReg <= wrData[0];
      if (strb.wrPmr)  pmrReg <= wrData[PRIO_W-1:0];
      if (strb.ackRd && ackValid) activeVec[ackIdx] <= 1'b1;
      if (eoiHit) activeVec[eoiIdx] <= 1'b0;
    end
  end

  assert_mask_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pmrReg == PMR_RESET && activeVec == '0 && !enReg));

  assert_winner_below_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (prioArr[ackIdx] < pmrReg));

  assert_no_irq_disabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |-> (!irqOut && rdData[ID_W-1:0] == SPURIOUS_ID) || regSel != 2'd2);

  assert_ack_sets_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackRd && ackValid) |=> activeVec[$past(ackIdx)]);

  assert_winner_not_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> !activeVec[ackIdx]);

  assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    eoiHit |=> !activeVec[$past(eoiIdx)]);

  assert_eoi_miss_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiWr && !eoiHit) |=> activeVec == $past(activeVec));

  assert_valid_id_limit_R10: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (32'(ackId) <= VALID_ID_MAX));
endmodule

// File: rtl/cpu_ack_iface.sv
module cpu_ack_iface
  import ackif_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8,
  parameter logic [PRIO_W-1:0] PMR_RESET = 8'hF0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        pendVec,
  input  logic [NUM_SRC*PRIO_W-1:0] prioVec,
  input  logic [1:0]                regSel,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic [31:0]               wrData,
  output logic [31:0]               rdData,
  output logic                      irqOut
);
  strobe_t strb;

  ackif_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strb   (strb)
  );

  ackif_datapath #(
    .NUM_SRC   (NUM_SRC),
    .PRIO_W    (PRIO_W),
    .PMR_RESET (PMR_RESET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pendVec (pendVec),
    .prioVec (prioVec),
    .strb    (strb),
    .regSel  (regSel),
    .wrData  (wrData),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/cpu_ack_iface_bench.sv
`timescale 1ns/1ps
module cpu_ack_iface_bench;
  localparam int NS = 64;
  localparam int PW = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NS-1:0]     pendVec = '0;
  logic [NS*PW-1:0]  prioVec = '0;
  logic [1:0]        regSel = 2'd0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [31:0]       wrData = 32'd0;
  logic [31:0]       rdData;
  logic              irqOut;

  int checks = 0;
  int fails  = 0;

  // bench model
  bit [NS-1:0] mActive;
  bit          mEn;
  int          mPmr;
  int          prioM [NS];

  always #2.5 clk = ~clk;

  cpu_ack_iface #(.NUM_SRC(NS), .PRIO_W(PW)) u_cpu_ack_iface (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .prioVec(prioVec),
    .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refAck();
    int best = -1;
    int bp = 0;
    if (!mEn) return 1023;
    for (int i = 0; i < NS; i++)
      if (pendVec[i] && !mActive[i] && prioM[i] < mPmr && (best < 0 || prioM[i] < bp)) begin
        best = i;
        bp = prioM[i];
      end
    return (best < 0) ? 1023 : best;
  endfunction

  function automatic int refIrq();
    return (refAck() != 1023) ? 1 : 0;
  endfunction

  task automatic setSrc(input int id, input bit p, input int pr);
    @(negedge clk);
    pendVec[id] = p;
    prioM[id] = pr;
    prioVec[id*PW +: PW] = PW'(pr);
  endtask

  task automatic busWrite(input int sel, input int data);
    @(negedge clk);
    regSel = 2'(sel); wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    if (sel == 0) mEn = data[0];
    if (sel == 1) mPmr = data & 8'hFF;
    if (sel == 3 && (data & 10'h3FF) < NS && mActive[data & 10'h3FF]) mActive[data & 10'h3FF] = 1'b0;
  endtask

  task automatic busRead(input int sel, output int data);
    @(negedge clk);
    regSel = 2'(sel); rdEn = 1'b1;
    #1 data = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // acknowledge with check against the model, then update the model
  task automatic ackCheck(input string req, output int id);
    int exp;
    exp = refAck();
    busRead(2, id);
    check(req, id, exp);
    if (exp != 1023) mActive[exp] = 1'b1;
  endtask

  task automatic irqCheck(input string req);
    #1 check(req, irqOut, refIrq());
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v;
    int id;
    void'($urandom(32'd2718));
    mActive = '0; mEn = 1'b0; mPmr = 8'hF0;
    for (int i = 0; i < NS; i++) prioM[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(0, v); check("R1 ctrl", v, 0);
    busRead(1, v); check("R1 mask", v, 8'hF0);
    busRead(2, v); check("R1 ack", v, 1023);
    #1 check("R1 irq", irqOut, 0);

    // R4 disabled: pending source is not signalled or acknowledged
    setSrc(3, 1, 8'h10);
    #1 check("R4 irq disabled", irqOut, 0);
    ackCheck("R4 ack disabled", v);
    busWrite(0, 1);
    irqCheck("R8 irq enabled");
    check("R8 irq value", irqOut, 1);

    // R9 IPI range, R5 active blocks re-ack
    ackCheck("R9 ipi ack", v); check("R9 ipi id", v, 3);
    irqCheck("R5 irq after ack"); check("R5 irq low", irqOut, 0);
    ackCheck("R5 second ack", v); check("R10 spurious", v, 1023);

    // R7 eoi of idle id and out-of-range id
    busWrite(3, 7);
    busWrite(3, 100);
    ackCheck("R7 eoi miss", v); check("R7 still active", v, 1023);
    // R6 eoi hit
    busWrite(3, 3);
    irqCheck("R6 irq after eoi");
    ackCheck("R6 reack", v); check("R6 id", v, 3);
    busWrite(3, 3);
    setSrc(3, 0, 8'h10);

    // R3 equal to mask is masked; R9 PPI range
    setSrc(20, 1, 8'hF0);
    irqCheck("R3 equal mask irq"); check("R3 irq low", irqOut, 0);
    busWrite(1, 8'hF1);
    irqCheck("R3 mask raised");
    ackCheck("R9 ppi ack", v); check("R9 ppi id", v, 20);
    busWrite(3, 20);
    setSrc(20, 0, 0);
    busWrite(1, 8'hF0);

    // R2 ties and priority ordering
    setSrc(40, 1, 8'h30);
    setSrc(33, 1, 8'h30);
    setSrc(50, 1, 8'h20);
    ackCheck("R2 prio", v); check("R2 lowest value", v, 50);
    ackCheck("R2 tie", v); check("R2 lowest id", v, 33);
    // R4 disable does not change active state
    busWrite(0, 0);
    ackCheck("R4 ack while off", v); check("R4 spurious", v, 1023);
    busWrite(0, 1);
    ackCheck("R4 resumes", v); check("R4 id", v, 40);
    busRead(2, v); check("R10 upper bits zero", v >> 10, 0);
    busWrite(3, 50); busWrite(3, 33); busWrite(3, 40);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op == 0) begin
        for (int i = 0; i < NS; i++) begin
          int sel;
          sel = $urandom_range(0, 4);
          prioM[i] = (sel == 0) ? 8'h00 : (sel == 1) ? 8'h40 : (sel == 2) ? 8'h80 :
                     (sel == 3) ? 8'hF0 : 8'hFF;
          prioVec[i*PW +: PW] = PW'(prioM[i]);
        end
        pendVec = {$urandom, $urandom} & {$urandom, $urandom};
      end else if (op <= 4) begin
        ackCheck("R2 random ack", v);
      end else if (op <= 7) begin
        id = $urandom_range(0, 127);
        if (op == 7 && mActive != '0) begin
          for (int i = 0; i < NS; i++) if (mActive[i]) id = i;
        end
        busWrite(3, id);
      end else if (op == 8) begin
        busWrite(1, $urandom_range(0, 255));
      end else begin
        busWrite(0, ($urandom_range(0, 3) != 0) ? 1 : 0);
      end
      irqCheck("R8 random irq");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule